// File: doc/BRIEF.md
# Pulse-Ramp DAC Step Sequencer

This block is the control state machine for an external integrating, time-based DAC. One request sends the analog chain through one full conversion. First the integrator capacitor is shorted. Then the reference is gated into the integrator for a timed number of clocks, which builds a ramp. After the ramp settles, the cycle ends in one of two ways: an emit cycle steers the ramp onto one hold capacitor through the output multiplexer, and a tune cycle samples the ramp comparator and reports its result.

The sequencer drives four things outward: the discharge switch, the reference chopper, the ramp polarity select, and the multiplexer inhibit and address. The durations of the discharge, settle and transfer phases come from cycle-count inputs. The pulse width is a 16-bit count. A scheduler above this block issues the emit and tune requests and consumes the done strobe.

The states are IDLE, DISCH, PULSE, SETTLE, XFER and EVAL. The transitions are:
- IDLE→DISCH on a request.
- DISCH→PULSE, PULSE→SETTLE and SETTLE→XFER/EVAL, each taken when its phase count expires.
- XFER→IDLE when its count expires.
- EVAL→IDLE after one clock.

Top module: `pulse_dac_seq`

## Requirements
- R1: After reset, busy and done are low, discharge_on is high, chop_to_int is low and mux_inhibit is high.
- R2: In IDLE, emit_req or tune_req moves the sequencer to DISCH on the next clock. If both are high in the same clock, the cycle is a tune cycle.
- R3: DISCH lasts dis_cycles clocks and SETTLE lasts settle_cycles clocks. PULSE lasts pulse_width clocks, with pulse_width sampled on the clock that leaves DISCH. A count of zero acts as one.
- R4: An emit cycle goes SETTLE→XFER. XFER lasts xfer_cycles clocks (zero acts as one). mux_inhibit is low only during XFER, and mux_addr equals the chan_sel value captured when the request was accepted.
- R5: A tune cycle goes SETTLE→EVAL for exactly one clock and samples cmp_in there. mux_inhibit stays high for the whole tune cycle.
- R6: discharge_on is high in IDLE and DISCH and low in PULSE, SETTLE, XFER and EVAL.
- R7: chop_to_int is high exactly during PULSE. High means the reference is routed into the integrator and low means it is routed to ground.
- R8: pol_neg (1 selects the negative ramp) and mux_addr hold the values captured at acceptance for the whole cycle.
- R9: done pulses for one clock in the first IDLE clock after XFER or EVAL. done_tune is 1 with that pulse when the cycle was a tune cycle. tune_bit then holds the cmp_in value sampled in EVAL.
- R10: busy is high in every state other than IDLE. Requests and changes on chan_sel or ramp_neg while busy have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| emit_req | input | 1 | Start an emit cycle |
| tune_req | input | 1 | Start a tune cycle (wins over emit) |
| chan_sel | input | CH_W | Output channel for the cycle |
| ramp_neg | input | 1 | 1 selects the negative ramp |
| cmp_in | input | 1 | Ramp comparator result |
| pulse_width | input | PW_W | Pulse length in clocks |
| dis_cycles | input | CNT_W | Discharge length in clocks |
| settle_cycles | input | CNT_W | Settle length in clocks |
| xfer_cycles | input | CNT_W | Transfer length in clocks |
| busy | output | 1 | A cycle is in progress |
| discharge_on | output | 1 | Integrator discharge switch engaged |
| chop_to_int | output | 1 | Reference routed into the integrator |
| pol_neg | output | 1 | Polarity select toward the multiplexer |
| mux_inhibit | output | 1 | Output multiplexer inhibited |
| mux_addr | output | CH_W | Output multiplexer channel address |
| done | output | 1 | One-clock end-of-cycle strobe |
| done_tune | output | 1 | The ending cycle was a tune cycle |
| tune_bit | output | 1 | Comparator bit sampled in EVAL |

## Verification
The assertions assume rst_n is held low before the first clock edge, so that no check sees a state that was never reset. The tune-bit property also assumes cmp_in is only meaningful at the EVAL clock. The bench sets cmp_in before each tune request and holds it steady through EVAL. It also keeps pulse_width steady over each cycle, so the sampled width is never ambiguous. Requests injected during a busy cycle carry a different channel and polarity, which checks that the latched selection holds.

// File: rtl/pdac_pkg.sv
package pdac_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_DISCH  = 3'd1,
        ST_PULSE  = 3'd2,
        ST_SETTLE = 3'd3,
        ST_XFER   = 3'd4,
        ST_EVAL   = 3'd5
    } seq_state_e;
endpackage

// File: rtl/pdac_timer.sv
module pdac_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         last
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    // A phase of N clocks (zero treated as one) ends when the count reaches one or zero.
    assign last = (cnt_q <= W'(1));
endmodule

// File: rtl/pdac_ctrl.sv
module pdac_ctrl
    import pdac_pkg::*;
#(
    parameter int CH_W  = 3,
    parameter int CNT_W = 16,
    parameter int PW_W  = 16,
    parameter int TW    = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            emit_req,
    input  logic            tune_req,
    input  logic [CH_W-1:0] chan_sel,
    input  logic            ramp_neg,
    input  logic            cmp_in,
    input  logic [PW_W-1:0] pulse_width,
    input  logic [CNT_W-1:0] dis_cycles,
    input  logic [CNT_W-1:0] settle_cycles,
    input  logic [CNT_W-1:0] xfer_cycles,
    input  logic            tmr_last,
    output logic            tmr_load,
    output logic [TW-1:0]   tmr_val,
    output logic            busy,
    output logic            discharge_on,
    output logic            chop_to_int,
    output logic            pol_neg,
    output logic            mux_inhibit,
    output logic [CH_W-1:0] mux_addr,
    output logic            done,
    output logic            done_tune,
    output logic            tune_bit
);
    seq_state_e      state_q, state_d;
    logic            tune_q, neg_q, bit_q, done_q, dtune_q;
    logic [CH_W-1:0] chan_q;
    logic            accept;

    assign accept = (state_q == ST_IDLE) && (emit_req || tune_req);

    // Next state and phase timer loading
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (emit_req || tune_req) begin
                    state_d  = ST_DISCH;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(dis_cycles);
                end
            end
            ST_DISCH: begin
                if (tmr_last) begin
                    state_d  = ST_PULSE;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(pulse_width);
                end
            end
            ST_PULSE: begin
                if (tmr_last) begin
                    state_d  = ST_SETTLE;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(settle_cycles);
                end
            end
            ST_SETTLE: begin
                if (tmr_last) begin
                    if (tune_q) begin
                        state_d = ST_EVAL;
                    end else begin
                        state_d  = ST_XFER;
                        tmr_load = 1'b1;
                        tmr_val  = TW'(xfer_cycles);
                    end
                end
            end
            ST_XFER: begin
                if (tmr_last)
                    state_d = ST_IDLE;
            end
            ST_EVAL: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Cycle context capture and result strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tune_q  <= 1'b0;
            neg_q   <= 1'b0;
            chan_q  <= '0;
            bit_q   <= 1'b0;
            done_q  <= 1'b0;
            dtune_q <= 1'b0;
        end else begin
            if (accept) begin
                tune_q <= tune_req;
                neg_q  <= ramp_neg;
                chan_q <= chan_sel;
            end
            if (state_q == ST_EVAL)
                bit_q <= cmp_in;
            done_q  <= (state_q == ST_EVAL) || ((state_q == ST_XFER) && tmr_last);
            dtune_q <= (state_q == ST_EVAL);
        end
    end

    // Output decode
    always_comb begin
        busy         = (state_q != ST_IDLE);
        discharge_on = (state_q == ST_IDLE) || (state_q == ST_DISCH);
        chop_to_int  = (state_q == ST_PULSE);
        mux_inhibit  = (state_q != ST_XFER);
        pol_neg      = neg_q;
        mux_addr     = chan_q;
        done         = done_q;
        done_tune    = dtune_q;
        tune_bit     = bit_q;
    end
endmodule

// File: rtl/pulse_dac_seq.sv
module pulse_dac_seq #(
    parameter int CH_W  = 3,
    parameter int CNT_W = 16,
    parameter int PW_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             emit_req,
    input  logic             tune_req,
    input  logic [CH_W-1:0]  chan_sel,
    input  logic             ramp_neg,
    input  logic             cmp_in,
    input  logic [PW_W-1:0]  pulse_width,
    input  logic [CNT_W-1:0] dis_cycles,
    input  logic [CNT_W-1:0] settle_cycles,
    input  logic [CNT_W-1:0] xfer_cycles,
    output logic             busy,
    output logic             discharge_on,
    output logic             chop_to_int,
    output logic             pol_neg,
    output logic             mux_inhibit,
    output logic [CH_W-1:0]  mux_addr,
    output logic             done,
    output logic             done_tune,
    output logic             tune_bit
);
    localparam int TW = (CNT_W > PW_W) ? CNT_W : PW_W;

    logic          tmr_load, tmr_last;
    logic [TW-1:0] tmr_val;

    pdac_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    pdac_ctrl #(.CH_W(CH_W), .CNT_W(CNT_W), .PW_W(PW_W), .TW(TW)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .emit_req      (emit_req),
        .tune_req      (tune_req),
        .chan_sel      (chan_sel),
        .ramp_neg      (ramp_neg),
        .cmp_in        (cmp_in),
        .pulse_width   (pulse_width),
        .dis_cycles    (dis_cycles),
        .settle_cycles (settle_cycles),
        .xfer_cycles   (xfer_cycles),
        .tmr_last      (tmr_last),
        .tmr_load      (tmr_load),
        .tmr_val       (tmr_val),
        .busy          (busy),
        .discharge_on  (discharge_on),
        .chop_to_int   (chop_to_int),
        .pol_neg       (pol_neg),
        .mux_inhibit   (mux_inhibit),
        .mux_addr      (mux_addr),
        .done          (done),
        .done_tune     (done_tune),
        .tune_bit      (tune_bit)
    );
endmodule

// File: rtl/pdac_seq_chk.sv
module pdac_seq_chk #(
    parameter int CH_W = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            emit_req,
    input logic            tune_req,
    input logic            cmp_in,
    input logic            busy,
    input logic            discharge_on,
    input logic            chop_to_int,
    input logic            pol_neg,
    input logic            mux_inhibit,
    input logic [CH_W-1:0] mux_addr,
    input logic            done,
    input logic            done_tune,
    input logic            tune_bit
);
    p_req_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (emit_req || tune_req)) |=> (busy && discharge_on && !chop_to_int));

    p_mux_only_xfer_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !mux_inhibit |-> (busy && !discharge_on && !chop_to_int));

    p_tune_sample_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_tune) |-> (tune_bit == $past(cmp_in)));

    p_idle_discharge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (discharge_on && !chop_to_int && mux_inhibit));

    p_chop_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        chop_to_int |-> (!discharge_on && mux_inhibit));

    p_hold_select_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(mux_addr) && $stable(pol_neg)));

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_on_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

bind pulse_dac_seq pdac_seq_chk #(.CH_W(CH_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .emit_req     (emit_req),
    .tune_req     (tune_req),
    .cmp_in       (cmp_in),
    .busy         (busy),
    .discharge_on (discharge_on),
    .chop_to_int  (chop_to_int),
    .pol_neg      (pol_neg),
    .mux_inhibit  (mux_inhibit),
    .mux_addr     (mux_addr),
    .done         (done),
    .done_tune    (done_tune),
    .tune_bit     (tune_bit)
);

// File: tb/tb_pulse_dac_seq.sv
`timescale 1ns/1ps
module tb_pulse_dac_seq;
    localparam int CH_W = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            emit_req = 1'b0, tune_req = 1'b0, ramp_neg = 1'b0, cmp_in = 1'b0;
    logic [CH_W-1:0] chan_sel = '0;
    logic [15:0]     pulse_width = 16'd1, dis_cycles = 16'd1, settle_cycles = 16'd1, xfer_cycles = 16'd1;
    logic            busy, discharge_on, chop_to_int, pol_neg, mux_inhibit, done, done_tune, tune_bit;
    logic [CH_W-1:0] mux_addr;

    always #2.5 clk = ~clk;

    pulse_dac_seq #(.CH_W(CH_W)) dut (
        .clk(clk), .rst_n(rst_n), .emit_req(emit_req), .tune_req(tune_req),
        .chan_sel(chan_sel), .ramp_neg(ramp_neg), .cmp_in(cmp_in),
        .pulse_width(pulse_width), .dis_cycles(dis_cycles),
        .settle_cycles(settle_cycles), .xfer_cycles(xfer_cycles),
        .busy(busy), .discharge_on(discharge_on), .chop_to_int(chop_to_int),
        .pol_neg(pol_neg), .mux_inhibit(mux_inhibit), .mux_addr(mux_addr),
        .done(done), .done_tune(done_tune), .tune_bit(tune_bit)
    );

    typedef struct {
        bit              tune;
        logic [CH_W-1:0] ch;
        bit              neg;
        int              busy_len;
        int              dis_len;
        int              chop_len;
        int              xfer_len;
        bit              tbit;
    } exp_t;

    exp_t q[$];
    int   checks = 0, errors = 0, n_done = 0;
    bit   finished = 0;

    task automatic chk(string req, bit ok, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int atleast1(int v);
        return (v == 0) ? 1 : v;
    endfunction

    // Monitor: measures each cycle at the ports and compares against the queue on done
    int              m_busy = 0, m_dis = 0, m_chop = 0, m_xfer = 0;
    logic [CH_W-1:0] m_addr = '0;
    bit              m_pol = 0, m_pol_chg = 0;

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (busy) begin
                if (m_busy == 0) m_pol = pol_neg;
                else if (pol_neg != m_pol) m_pol_chg = 1;
                m_busy++;
                if (discharge_on) m_dis++;
                if (chop_to_int) m_chop++;
                if (!mux_inhibit) begin
                    m_xfer++;
                    m_addr = mux_addr;
                end
            end else begin
                if (!discharge_on || chop_to_int || !mux_inhibit)
                    chk("R6 idle outputs", 0, {discharge_on, chop_to_int, mux_inhibit}, 3'b101);
            end
            if (done) begin
                exp_t e;
                n_done++;
                if (q.size() == 0) begin
                    chk("R10 unexpected done", 0, 1, 0);
                end else begin
                    e = q.pop_front();
                    chk("R9 done while idle", !busy, busy, 0);
                    chk("R3 busy length", m_busy == e.busy_len, m_busy, e.busy_len);
                    chk("R6 discharge length", m_dis == e.dis_len, m_dis, e.dis_len);
                    chk("R7 pulse length", m_chop == e.chop_len, m_chop, e.chop_len);
                    chk("R4 xfer length", m_xfer == e.xfer_len, m_xfer, e.xfer_len);
                    chk("R9 done_tune", done_tune == e.tune, done_tune, e.tune);
                    chk("R8 polarity", (m_pol == e.neg) && !m_pol_chg, m_pol, e.neg);
                    if (e.tune)
                        chk("R5 tune bit", tune_bit == e.tbit, tune_bit, e.tbit);
                    else
                        chk("R4 channel", m_addr == e.ch, m_addr, e.ch);
                end
                m_busy = 0; m_dis = 0; m_chop = 0; m_xfer = 0; m_pol_chg = 0;
            end
        end
    end

    // Driver: applies one request and pushes the expected result
    task automatic run_cycle(bit em, bit tn, logic [CH_W-1:0] ch, bit neg,
                             int d, int w, int s, int x, bit cmpv, bit poke);
        exp_t e;
        int   target;
        @(negedge clk);
        chan_sel = ch; ramp_neg = neg; cmp_in = cmpv;
        dis_cycles = 16'(d); pulse_width = 16'(w); settle_cycles = 16'(s); xfer_cycles = 16'(x);
        emit_req = em; tune_req = tn;
        e.tune = tn; e.ch = ch; e.neg = neg; e.tbit = cmpv;
        e.dis_len  = atleast1(d);
        e.chop_len = atleast1(w);
        e.xfer_len = tn ? 0 : atleast1(x);
        e.busy_len = atleast1(d) + atleast1(w) + atleast1(s) + (tn ? 1 : atleast1(x));
        q.push_back(e);
        target = n_done + 1;
        @(negedge clk);
        emit_req = 0; tune_req = 0;
        chk("R2 start in DISCH", busy && discharge_on && !chop_to_int, {busy, discharge_on}, 2'b11);
        if (poke) begin
            @(negedge clk);
            emit_req = 1; tune_req = 1; chan_sel = ~ch; ramp_neg = ~neg;
            @(negedge clk);
            emit_req = 0; tune_req = 0;
        end
        wait (n_done == target);
        repeat (2) @(negedge clk);
        chk("R10 no extra cycle", !busy, busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 busy", busy == 0, busy, 0);
        chk("R1 done", done == 0, done, 0);
        chk("R1 discharge_on", discharge_on == 1, discharge_on, 1);
        chk("R1 chop_to_int", chop_to_int == 0, chop_to_int, 0);
        chk("R1 mux_inhibit", mux_inhibit == 1, mux_inhibit, 1);
        rst_n = 1;
        repeat (2) @(negedge clk);
        // R4 plain emit
        run_cycle(1, 0, 3'd5, 0, 3, 4, 2, 3, 0, 0);
        // R5 tune, comparator high then low
        run_cycle(0, 1, 3'd1, 1, 2, 6, 3, 2, 1, 0);
        run_cycle(0, 1, 3'd6, 0, 1, 1, 1, 1, 0, 0);
        // R3 zero counts act as one
        run_cycle(1, 0, 3'd0, 1, 0, 0, 0, 0, 0, 0);
        // R2 both requests: tune wins
        run_cycle(1, 1, 3'd2, 0, 2, 3, 2, 4, 1, 0);
        // R10 requests and selection changes while busy are ignored
        run_cycle(1, 0, 3'd7, 1, 4, 10, 2, 2, 0, 1);
        run_cycle(0, 1, 3'd4, 0, 3, 5, 2, 2, 1, 1);
        // R3 long pulse
        run_cycle(1, 0, 3'd3, 0, 2, 300, 5, 6, 0, 0);
        chk("R9 all cycles completed", q.size() == 0, q.size(), 0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL R10 watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule